// File: doc/BRIEF.md
# Time-Triggered Schedule Organizer

This block walks a host-loaded table of time triggers once per basic cycle of a time-triggered network node. It compares the current cycle time with each entry's time mark, and checks the current cycle count against the entry's cycle filter. When an entry is due, the block issues the matching action as a one-clock pulse, tagged with the entry's linked message index. The actions are a data transmission, a reception check, a reference-message transmission, or a watch (missing-reference) alarm. Frame transmission and reception on the bus are handled elsewhere. This block only decides when and what.

Two sets of reference and watch triggers exist. The gap bit carried by the most recent reference message selects which set is live. In gap mode, the point where the normal reference trigger would have fired becomes the start of a time gap, provided the event input is high there. A falling edge of the event input inside that gap triggers the reference message early. The gap reference trigger is the fallback. A host request marks the next issued reference message as announcing a gap.

Top module: `tt_sched_org`

## Requirements
- R1: After synchronous reset all action pulses, `fire_msg`, `ref_gap_bit`, `err_no_ref` and `err_rx_miss` are zero.
- R2: Entries are visited strictly in table order, at most one per clock, starting from entry 0 after each `cycle_start`. An entry is visited on the first clock edge at which `cycle_time` >= its mark. Its action pulse appears on the outputs right after that edge. Kind codes: 0 none, 1 transmit, 2 receive check, 3 reference, 4 gap reference, 5 watch, 6 gap watch.
- R3: An entry acts only in cycles where (`cycle_count` AND repeat mask) equals its base cycle; otherwise it is skipped silently.
- R4: Transmit entries produce `tx_fire` only while `in_sync` is high.
- R5: A reference action requires `is_master` high, and at most one reference action is issued per basic cycle.
- R6: `ref_gap_in` sampled at `cycle_start` selects the mode. In normal mode, kinds 4 and 6 are ignored. In gap mode, kinds 3 and 5 never fire.
- R7: A live watch entry pulses `watch_fire` and sets `err_no_ref`. `err_no_ref` stays high until the next `cycle_start`.
- R8: In gap mode, visiting the kind-3 entry while `evt_in` is high opens a gap. A falling edge of `evt_in` during the gap then issues the reference action with that entry's message index. Falling edges while no gap is open are ignored.
- R9: In gap mode with no event-triggered reference, the kind-4 entry issues the reference action.
- R10: A receive check on message m sets `err_rx_miss[m]` if no `rx_valid` with `rx_msg`=m arrived since the previous check of m (or since reset). Otherwise it clears the bit. The bits change only at checks.
- R11: A `host_gap_req` pulse makes `ref_gap_bit` high with the next reference action only. It is then cleared.
- R12: At most one action pulse is high per clock. An event-triggered reference takes that clock, and the table visit waits one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | $clog2(N_ENTRIES) | Table entry to write |
| cfg_mark | input | TM_W | Time mark of written entry |
| cfg_kind | input | 3 | Kind code of written entry |
| cfg_msg | input | MSG_W | Linked message index |
| cfg_base | input | CC_W | Base cycle of the cycle filter |
| cfg_rep | input | CC_W | Repeat mask (power of two minus one) |
| cycle_time | input | TM_W | Current cycle time |
| cycle_count | input | CC_W | Current basic-cycle number |
| cycle_start | input | 1 | Pulse: a valid reference message started a new basic cycle |
| ref_gap_in | input | 1 | Gap bit of that reference message |
| in_sync | input | 1 | Node is synchronized |
| is_master | input | 1 | Node is current or potential time master |
| evt_in | input | 1 | External event level |
| host_gap_req | input | 1 | Pulse: announce a gap in the next reference |
| rx_valid | input | 1 | Pulse: a message was received |
| rx_msg | input | MSG_W | Index of the received message |
| tx_fire | output | 1 | Transmit action pulse |
| rxchk_fire | output | 1 | Receive-check action pulse |
| ref_fire | output | 1 | Reference action pulse |
| watch_fire | output | 1 | Watch alarm pulse |
| fire_msg | output | MSG_W | Message index of the current action |
| ref_gap_bit | output | 1 | Gap bit for the reference being issued |
| err_no_ref | output | 1 | Missing reference message flag |
| err_rx_miss | output | 2**MSG_W | Per-message missing-reception flags |

## Verification
A stale or skipped table pointer shows at the ports within one clock of the next due mark. The action pulse or message index is then out of order, or a trigger is repeated or lost. Because one entry is visited per clock, each wrong step surfaces on its own edge. A wrong gap-mode or gap-open state appears at the next reference or watch position, as a reference pulse issued from the wrong set or a missing early reference. Stale reception bookkeeping appears as a wrong `err_rx_miss` bit on the very clock of the next check for that message.

// File: rtl/tt_sched_pkg.sv
// Shared definitions for the time-triggered schedule organizer.
// Assumes: kind codes are fixed and visible to the host loading the table.
package tt_sched_pkg;
    typedef enum logic [2:0] {
        KIND_NONE      = 3'd0,
        KIND_TX        = 3'd1,
        KIND_RXCHK     = 3'd2,
        KIND_REF       = 3'd3,
        KIND_REF_GAP   = 3'd4,
        KIND_WATCH     = 3'd5,
        KIND_WATCH_GAP = 3'd6,
        KIND_SPARE     = 3'd7
    } trig_kind_e;
endpackage

// File: rtl/tt_trig_table.sv
// Trigger table: host-written register array with one asynchronous read port.
// Assumes: the host stores entries in ascending time-mark order; reset clears
// every entry to kind NONE so an unloaded table produces no action.
module tt_trig_table
    import tt_sched_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int TM_W      = 16,
    parameter int CC_W      = 6,
    parameter int MSG_W     = 4,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  logic [TM_W-1:0]  wmark,
    input  trig_kind_e       wkind,
    input  logic [MSG_W-1:0] wmsg,
    input  logic [CC_W-1:0]  wbase,
    input  logic [CC_W-1:0]  wrep,
    input  logic [IDX_W-1:0] raddr,
    output logic [TM_W-1:0]  rmark,
    output trig_kind_e       rkind,
    output logic [MSG_W-1:0] rmsg,
    output logic [CC_W-1:0]  rbase,
    output logic [CC_W-1:0]  rrep
);
    logic [TM_W-1:0]  mark_q [N_ENTRIES];
    trig_kind_e       kind_q [N_ENTRIES];
    logic [MSG_W-1:0] msg_q  [N_ENTRIES];
    logic [CC_W-1:0]  base_q [N_ENTRIES];
    logic [CC_W-1:0]  rep_q  [N_ENTRIES];

    // Store a host write into the addressed entry; clear all on reset.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (!rst_n) begin
                mark_q[i] <= '0;
                kind_q[i] <= KIND_NONE;
                msg_q[i]  <= '0;
                base_q[i] <= '0;
                rep_q[i]  <= '0;
            end else if (we && waddr == IDX_W'(i)) begin
                mark_q[i] <= wmark;
                kind_q[i] <= wkind;
                msg_q[i]  <= wmsg;
                base_q[i] <= wbase;
                rep_q[i]  <= wrep;
            end
        end
    end

    // Present the entry under the scan pointer.
    always_comb begin
        rmark = mark_q[raddr];
        rkind = kind_q[raddr];
        rmsg  = msg_q[raddr];
        rbase = base_q[raddr];
        rrep  = rep_q[raddr];
    end
endmodule

// File: rtl/tt_gap_ctl.sv
// Gap controller: holds the trigger-set selection taken from the last
// reference message, the open-gap window, event falling-edge detection and
// the pending host request for announcing a gap.
// Assumes: evt_in is already synchronous to clk.
module tt_gap_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cycle_start,
    input  logic ref_gap_in,
    input  logic evt_in,
    input  logic host_gap_req,
    input  logic open_req,
    input  logic ref_fired,
    output logic gap_mode,
    output logic evt_ref_req,
    output logic pend_gap
);
    logic gap_open_q;
    logic evt_q;
    logic pend_q;

    // Remember the event level of the previous clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= 1'b0;
        else        evt_q <= evt_in;
    end

    // Load the trigger-set selection at each new basic cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)           gap_mode <= 1'b0;
        else if (cycle_start) gap_mode <= ref_gap_in;
    end

    // Open the gap window at the normal reference position if the event is high.
    always_ff @(posedge clk) begin
        if (!rst_n)                       gap_open_q <= 1'b0;
        else if (cycle_start || ref_fired) gap_open_q <= 1'b0;
        else if (open_req && evt_in)      gap_open_q <= 1'b1;
    end

    // Keep a host gap request until a reference action consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n)         pend_q <= 1'b0;
        else if (ref_fired) pend_q <= 1'b0;
        else                pend_q <= pend_q | host_gap_req;
    end

    assign evt_ref_req = gap_open_q && evt_q && !evt_in;
    assign pend_gap    = pend_q | host_gap_req;

    AST_GAP_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle_start |=> $stable(gap_mode)); // R6
    AST_NO_EVT_OUTSIDE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cycle_start) |-> !evt_ref_req); // R8
endmodule

// File: rtl/tt_rx_monitor.sv
// Reception monitor: notes receptions per message index and judges each
// receive check, keeping one missing-reception flag per message.
// Assumes: at most one reception and one check are reported per clock.
module tt_rx_monitor #(
    parameter int MSG_W = 4,
    localparam int N_MSG = 1 << MSG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_valid,
    input  logic [MSG_W-1:0] rx_msg,
    input  logic             chk,
    input  logic [MSG_W-1:0] chk_msg,
    output logic [N_MSG-1:0] err_miss
);
    logic [N_MSG-1:0] seen_q;
    logic [N_MSG-1:0] rx_hit;
    logic [N_MSG-1:0] chk_hit;

    for (genvar i = 0; i < N_MSG; i++) begin : g_dec
        assign rx_hit[i]  = rx_valid && (rx_msg == MSG_W'(i));
        assign chk_hit[i] = chk && (chk_msg == MSG_W'(i));
    end

    // Track receptions since the last check and grade each check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q   <= '0;
            err_miss <= '0;
        end else begin
            for (int i = 0; i < N_MSG; i++) begin
                if (chk_hit[i]) begin
                    err_miss[i] <= !(seen_q[i] || rx_hit[i]);
                    seen_q[i]   <= 1'b0;
                end else if (rx_hit[i]) begin
                    seen_q[i]   <= 1'b1;
                end
            end
        end
    end

    AST_RX_ERR_ON_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        !chk |=> $stable(err_miss)); // R10
endmodule

// File: rtl/tt_sched_org.sv
// Schedule organizer top: scans the trigger table one entry per clock,
// filters entries by cycle count, mode, sync and master state, and issues
// one action pulse per clock with the linked message index.
// Assumes: cycle_start is a one-clock pulse coinciding with cycle_time restart.
module tt_sched_org
    import tt_sched_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int TM_W      = 16,
    parameter int CC_W      = 6,
    parameter int MSG_W     = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cfg_we,
    input  logic [$clog2(N_ENTRIES)-1:0] cfg_addr,
    input  logic [TM_W-1:0]              cfg_mark,
    input  logic [2:0]                   cfg_kind,
    input  logic [MSG_W-1:0]             cfg_msg,
    input  logic [CC_W-1:0]              cfg_base,
    input  logic [CC_W-1:0]              cfg_rep,
    input  logic [TM_W-1:0]              cycle_time,
    input  logic [CC_W-1:0]              cycle_count,
    input  logic                         cycle_start,
    input  logic                         ref_gap_in,
    input  logic                         in_sync,
    input  logic                         is_master,
    input  logic                         evt_in,
    input  logic                         host_gap_req,
    input  logic                         rx_valid,
    input  logic [MSG_W-1:0]             rx_msg,
    output logic                         tx_fire,
    output logic                         rxchk_fire,
    output logic                         ref_fire,
    output logic                         watch_fire,
    output logic [MSG_W-1:0]             fire_msg,
    output logic                         ref_gap_bit,
    output logic                         err_no_ref,
    output logic [(1<<MSG_W)-1:0]        err_rx_miss
);
    localparam int IDX_W = $clog2(N_ENTRIES);
    localparam int PTR_W = $clog2(N_ENTRIES + 1);

    logic [PTR_W-1:0] ptr;
    logic             ref_done;
    logic [MSG_W-1:0] gap_msg_q;
    logic [TM_W-1:0]  e_mark;
    trig_kind_e       e_kind;
    logic [MSG_W-1:0] e_msg;
    logic [CC_W-1:0]  e_base;
    logic [CC_W-1:0]  e_rep;
    logic             gap_mode, evt_ref_req, pend_gap;
    logic             scan_done, applies, hit, evt_take;
    logic             act_tx, act_rx, act_ref, act_watch, act_open;
    logic             ref_now;

    tt_trig_table #(
        .N_ENTRIES(N_ENTRIES), .TM_W(TM_W), .CC_W(CC_W), .MSG_W(MSG_W)
    ) u_table (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .waddr(cfg_addr),
        .wmark(cfg_mark), .wkind(trig_kind_e'(cfg_kind)), .wmsg(cfg_msg),
        .wbase(cfg_base), .wrep(cfg_rep), .raddr(ptr[IDX_W-1:0]),
        .rmark(e_mark), .rkind(e_kind), .rmsg(e_msg), .rbase(e_base), .rrep(e_rep)
    );

    tt_gap_ctl u_gap (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .ref_gap_in(ref_gap_in),
        .evt_in(evt_in), .host_gap_req(host_gap_req), .open_req(hit && act_open),
        .ref_fired(ref_now), .gap_mode(gap_mode), .evt_ref_req(evt_ref_req),
        .pend_gap(pend_gap)
    );

    tt_rx_monitor #(.MSG_W(MSG_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_msg(rx_msg),
        .chk(hit && act_rx), .chk_msg(e_msg), .err_miss(err_rx_miss)
    );

    // Decide whether the entry under the pointer is due and what it does.
    always_comb begin
        scan_done = (ptr == PTR_W'(N_ENTRIES));
        applies   = ((cycle_count & e_rep) == e_base);
        evt_take  = evt_ref_req && is_master && !ref_done && !cycle_start;
        hit       = !scan_done && (cycle_time >= e_mark) && !cycle_start && !evt_take;
        act_tx    = applies && (e_kind == KIND_TX) && in_sync;
        act_rx    = applies && (e_kind == KIND_RXCHK);
        act_ref   = applies && is_master && !ref_done &&
                    ((e_kind == KIND_REF && !gap_mode) || (e_kind == KIND_REF_GAP && gap_mode));
        act_watch = applies && ((e_kind == KIND_WATCH && !gap_mode) ||
                                (e_kind == KIND_WATCH_GAP && gap_mode));
        act_open  = applies && gap_mode && (e_kind == KIND_REF);
        ref_now   = evt_take || (hit && act_ref);
    end

    // Advance the scan, register the action pulses and the cycle-level state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr         <= '0;
            ref_done    <= 1'b0;
            gap_msg_q   <= '0;
            tx_fire     <= 1'b0;
            rxchk_fire  <= 1'b0;
            ref_fire    <= 1'b0;
            watch_fire  <= 1'b0;
            fire_msg    <= '0;
            ref_gap_bit <= 1'b0;
            err_no_ref  <= 1'b0;
        end else begin
            tx_fire     <= 1'b0;
            rxchk_fire  <= 1'b0;
            ref_fire    <= 1'b0;
            watch_fire  <= 1'b0;
            fire_msg    <= '0;
            ref_gap_bit <= 1'b0;
            if (cycle_start) begin
                ptr        <= '0;
                ref_done   <= 1'b0;
                err_no_ref <= 1'b0;
            end else if (evt_take) begin
                ref_fire    <= 1'b1;
                fire_msg    <= gap_msg_q;
                ref_gap_bit <= pend_gap;
                ref_done    <= 1'b1;
            end else if (hit) begin
                ptr        <= ptr + 1'b1;
                tx_fire    <= act_tx;
                rxchk_fire <= act_rx;
                ref_fire   <= act_ref;
                watch_fire <= act_watch;
                if (act_tx || act_rx || act_ref || act_watch) fire_msg <= e_msg;
                if (act_ref) begin
                    ref_done    <= 1'b1;
                    ref_gap_bit <= pend_gap;
                end
                if (act_watch) err_no_ref <= 1'b1;
                if (act_open)  gap_msg_q  <= e_msg;
            end
        end
    end

    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_fire, rxchk_fire, ref_fire, watch_fire})); // R12
    AST_TX_NEEDS_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fire |-> $past(in_sync)); // R4
    AST_REF_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        ref_fire |-> $past(is_master)); // R5
    AST_WATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        watch_fire |-> err_no_ref); // R7
    AST_SCAN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_start |=> (ptr == '0)); // R2
endmodule

// File: tb/tt_sched_org_test.sv
// Directed bench for the schedule organizer: one task per scenario.
module tt_sched_org_test;
    localparam int NE = 8, TMW = 16, CCW = 6, MW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [TMW-1:0] cfg_mark = '0;
    logic [2:0] cfg_kind = '0;
    logic [MW-1:0] cfg_msg = '0;
    logic [CCW-1:0] cfg_base = '0, cfg_rep = '0;
    logic [TMW-1:0] cycle_time = '0;
    logic [CCW-1:0] cycle_count = '0;
    logic cycle_start = 1'b0, ref_gap_in = 1'b0, in_sync = 1'b0, is_master = 1'b0;
    logic evt_in = 1'b0, host_gap_req = 1'b0, rx_valid = 1'b0;
    logic [MW-1:0] rx_msg = '0;
    logic tx_fire, rxchk_fire, ref_fire, watch_fire, ref_gap_bit, err_no_ref;
    logic [MW-1:0] fire_msg;
    logic [15:0] err_rx_miss;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    tt_sched_org #(.N_ENTRIES(NE), .TM_W(TMW), .CC_W(CCW), .MSG_W(MW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_mark(cfg_mark), .cfg_kind(cfg_kind), .cfg_msg(cfg_msg),
        .cfg_base(cfg_base), .cfg_rep(cfg_rep), .cycle_time(cycle_time),
        .cycle_count(cycle_count), .cycle_start(cycle_start), .ref_gap_in(ref_gap_in),
        .in_sync(in_sync), .is_master(is_master), .evt_in(evt_in),
        .host_gap_req(host_gap_req), .rx_valid(rx_valid), .rx_msg(rx_msg),
        .tx_fire(tx_fire), .rxchk_fire(rxchk_fire), .ref_fire(ref_fire),
        .watch_fire(watch_fire), .fire_msg(fire_msg), .ref_gap_bit(ref_gap_bit),
        .err_no_ref(err_no_ref), .err_rx_miss(err_rx_miss)
    );

    always #2.5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Actions as {tx, rxchk, ref, watch}; message checked when any fires.
    task automatic expect_act(input string tag, input logic [3:0] act, input logic [MW-1:0] msg);
        check(tag, {28'd0, tx_fire, rxchk_fire, ref_fire, watch_fire}, {28'd0, act});
        if (act != 4'b0) check({tag, " msg"}, {28'd0, fire_msg}, {28'd0, msg});
    endtask

    task automatic wr(input int a, input int mark, input int kind, input int msg,
                      input int base, input int rep);
        cfg_we = 1'b1; cfg_addr = 3'(a); cfg_mark = TMW'(mark); cfg_kind = 3'(kind);
        cfg_msg = MW'(msg); cfg_base = CCW'(base); cfg_rep = CCW'(rep);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic new_cycle(input int cnt, input logic gap);
        cycle_start = 1'b1; ref_gap_in = gap; cycle_count = CCW'(cnt); cycle_time = '0;
        step();
        cycle_start = 1'b0; ref_gap_in = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
        check("R1 pulses", {28'd0, tx_fire, rxchk_fire, ref_fire, watch_fire}, 32'd0);
        check("R1 flags", {14'd0, err_no_ref, ref_gap_bit, err_rx_miss}, 32'd0);
        check("R1 msg", {28'd0, fire_msg}, 32'd0);
    endtask

    task automatic load_table();
        wr(0, 10, 1, 1, 0, 0);
        wr(1, 20, 2, 2, 0, 0);
        wr(2, 30, 1, 3, 1, 1);
        wr(3, 40, 3, 0, 0, 0);
        wr(4, 50, 4, 0, 0, 0);
        wr(5, 60, 5, 0, 0, 0);
        wr(6, 70, 6, 0, 0, 0);
        wr(7, 100, 0, 0, 0, 0);
        check("R1 no action while loading", {31'd0, tx_fire | ref_fire}, 32'd0);
    endtask

    task automatic t_normal_cycle();
        in_sync = 1'b1; is_master = 1'b1;
        new_cycle(0, 1'b0);
        cycle_time = 9;  step(); expect_act("R2 before mark", 4'b0000, 0);
        cycle_time = 10; step(); expect_act("R2 tx at mark", 4'b1000, 1);
        step();                  expect_act("R2 entry visited once", 4'b0000, 0);
        cycle_time = 20; step(); expect_act("R10 rx check", 4'b0100, 2);
        check("R10 miss set", {16'd0, err_rx_miss}, 32'h0004);
        cycle_time = 30; step(); expect_act("R3 filtered out", 4'b0000, 0);
        cycle_time = 40; step(); expect_act("R5 ref as master", 4'b0010, 0);
        check("R11 no gap bit", {31'd0, ref_gap_bit}, 32'd0);
        cycle_time = 50; step(); expect_act("R6 gap ref ignored", 4'b0000, 0);
        cycle_time = 60; step(); expect_act("R7 watch", 4'b0001, 0);
        check("R7 err set", {31'd0, err_no_ref}, 32'd1);
        cycle_time = 70; step(); expect_act("R6 gap watch ignored", 4'b0000, 0);
        check("R7 err held", {31'd0, err_no_ref}, 32'd1);
    endtask

    task automatic t_sync_master_gate();
        in_sync = 1'b0; is_master = 1'b0;
        new_cycle(1, 1'b0);
        check("R7 err cleared", {31'd0, err_no_ref}, 32'd0);
        rx_valid = 1'b1; rx_msg = 2; step(); rx_valid = 1'b0;
        cycle_time = 10; step(); expect_act("R4 tx blocked", 4'b0000, 0);
        cycle_time = 20; step(); expect_act("R10 rx check", 4'b0100, 2);
        check("R10 miss cleared", {16'd0, err_rx_miss}, 32'h0000);
        in_sync = 1'b1;
        cycle_time = 30; step(); expect_act("R3 odd cycle tx", 4'b1000, 3);
        cycle_time = 40; step(); expect_act("R5 no ref as slave", 4'b0000, 0);
    endtask

    task automatic t_host_gap();
        is_master = 1'b1; in_sync = 1'b1;
        host_gap_req = 1'b1; step(); host_gap_req = 1'b0;
        new_cycle(2, 1'b0);
        cycle_time = 40;
        step(); expect_act("R2 order first", 4'b1000, 1);
        step(); expect_act("R2 order second", 4'b0100, 2);
        check("R10 miss again", {16'd0, err_rx_miss}, 32'h0004);
        step(); expect_act("R3 even cycle skip", 4'b0000, 0);
        step(); expect_act("R11 ref", 4'b0010, 0);
        check("R11 gap bit", {31'd0, ref_gap_bit}, 32'd1);
    endtask

    task automatic t_gap_fallback();
        evt_in = 1'b0;
        new_cycle(3, 1'b1);
        cycle_time = 40;
        step(); expect_act("R2 tx", 4'b1000, 1);
        step(); expect_act("R2 rx", 4'b0100, 2);
        step(); expect_act("R3 odd tx", 4'b1000, 3);
        step(); expect_act("R6 normal ref ignored", 4'b0000, 0);
        cycle_time = 50; step(); expect_act("R9 gap ref", 4'b0010, 0);
        check("R11 bit consumed", {31'd0, ref_gap_bit}, 32'd0);
        cycle_time = 60; step(); expect_act("R6 normal watch ignored", 4'b0000, 0);
        cycle_time = 70; step(); expect_act("R7 gap watch", 4'b0001, 0);
    endtask

    task automatic t_event_gap();
        new_cycle(0, 1'b1);
        evt_in = 1'b1; step();
        cycle_time = 5; evt_in = 1'b0; step();
        expect_act("R8 edge outside gap", 4'b0000, 0);
        evt_in = 1'b1;
        cycle_time = 40;
        step(); expect_act("R2 tx", 4'b1000, 1);
        step(); expect_act("R2 rx", 4'b0100, 2);
        step(); expect_act("R3 skip", 4'b0000, 0);
        step(); expect_act("R8 gap opens silently", 4'b0000, 0);
        cycle_time = 70; evt_in = 1'b0; step();
        expect_act("R8 event ref", 4'b0010, 0);
        step(); expect_act("R5 no second ref", 4'b0000, 0);
        step(); expect_act("R12 stalled scan resumes", 4'b0000, 0);
        step(); expect_act("R12 watch after stall", 4'b0001, 0);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        load_table();
        t_normal_cycle();
        t_sync_master_gate();
        t_host_gap();
        t_gap_fallback();
        t_event_gap();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule